// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register on a simple I/O bus, decoded at port address 0xCF9. Software writes it to ask for a system reset, or to choose which kind of reset a later request should mean. A write whose trigger bit (bit 2) is set does not change the register. Its only effect is a one-clock request pulse on `sys_rst_req`. Any other write to the port keeps only the reset-kind bit (bit 1) and stores zero in every other bit. A read of the port returns the held byte.

The pulse comes from a two-state machine. `ST_IDLE` is the quiet state. Transition `T_ARM` leaves `ST_IDLE` for `ST_FIRE` when a trigger write is decoded. `sys_rst_req` is high only while the machine is in `ST_FIRE`. From `ST_FIRE`, transition `T_DONE` returns to `ST_IDLE` when there is no new trigger. Transition `T_REARM` stays in `ST_FIRE` when another trigger write arrives in that cycle. The held byte and the state machine are both cleared by the active-low system reset. The actual reset sequencing happens outside this block.

Top module: `rst_ctl_port`

## Requirements
- R1: While `rst_n` is low and just after its release, the held byte is 0x00 and `sys_rst_req` is low.
- R2: A read (`io_rd` high) at address 0xCF9 returns the held byte on `io_rdata` in the same cycle. When no read of that address is in progress, `io_rdata` is 0x00.
- R3: A write at 0xCF9 with bit 2 clear stores `io_wdata & 8'h02`. Only bit 1 (reset kind) is kept, and every other stored bit reads back 0.
- R4: A write at 0xCF9 with bit 2 set drives `sys_rst_req` high in the cycle that follows the clock edge capturing the write. It leaves the held byte unchanged.
- R5: One isolated trigger write gives a `sys_rst_req` pulse exactly one clock wide. Trigger writes in consecutive cycles keep the request high for one cycle per write.
- R6: Writes to any other address neither change the held byte nor raise `sys_rst_req`.
- R7: Reads never change the held byte and never raise `sys_rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, 0x00 when the port is not being read |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The port is written with patterns that separate the two paths. A byte with only bit 1 set is stored. A byte with every bit but bit 2 set is stored too, and it shows the masking of the other bits. A byte with bit 2 set on top of a stored value shows whether a trigger wrongly overwrites the register. Single triggers and back-to-back triggers tell a one-cycle pulse apart from a stuck or merged request. Writes with the trigger bit set to neighbouring addresses (0xCF8, 0xCFA, 0x0CF9 with high bits changed) and plain reads show that only a real write to the port changes anything.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int unsigned RCP_ADDR_W   = 16;
    localparam int unsigned RCP_DATA_W   = 8;
    localparam int unsigned RCP_PORT     = 32'h0000_0CF9;
    localparam int unsigned RCP_TRIG_BIT = 2;
    localparam int unsigned RCP_KIND_BIT = 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } rcp_state_e;

endpackage

// File: rtl/rcp_decode.sv
module rcp_decode #(
    parameter int unsigned ADDR_W   = rcp_pkg::RCP_ADDR_W,
    parameter int unsigned DATA_W   = rcp_pkg::RCP_DATA_W,
    parameter int unsigned PORT     = rcp_pkg::RCP_PORT,
    parameter int unsigned TRIG_BIT = rcp_pkg::RCP_TRIG_BIT
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              wr_store,
    output logic              wr_trig,
    output logic              rd_sel
);

    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT);

    logic hit;

    always_comb begin
        hit      = (io_addr == PORT_A);
        wr_trig  = hit && io_wr && io_wdata[TRIG_BIT];
        wr_store = hit && io_wr && !io_wdata[TRIG_BIT];
        rd_sel   = hit && io_rd;
    end

endmodule

// File: rtl/rcp_store.sv
module rcp_store #(
    parameter int unsigned DATA_W   = rcp_pkg::RCP_DATA_W,
    parameter int unsigned KIND_BIT = rcp_pkg::RCP_KIND_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_store,
    input  logic              wr_trig,
    input  logic              rd_sel,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata
);

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << KIND_BIT;

    logic [DATA_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (wr_store) begin
            held <= io_wdata & KEEP_MASK;
        end
    end

    always_comb begin
        io_rdata = rd_sel ? held : '0;
    end

    // R3: no bit outside the reset-kind position is ever held
    a_r3_only_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (held & ~KEEP_MASK) == '0);

    // R4: a trigger write leaves the held byte alone
    a_r4_trig_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trig |=> $stable(held));

    // R6: without a store strobe the held byte does not move
    a_r6_no_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_store |=> $stable(held));

endmodule

// File: rtl/rcp_pulse.sv
module rcp_pulse
    import rcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_trig,
    output logic sys_rst_req
);

    rcp_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (wr_trig) state_nx = ST_FIRE;                 // T_ARM
            ST_FIRE: state_nx = wr_trig ? ST_FIRE : ST_IDLE;          // T_REARM / T_DONE
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        sys_rst_req = (state == ST_FIRE);
    end

    // R5: a pulse with no fresh trigger ends after one cycle
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !wr_trig) |=> !sys_rst_req);

endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port #(
    parameter int unsigned ADDR_W   = rcp_pkg::RCP_ADDR_W,
    parameter int unsigned DATA_W   = rcp_pkg::RCP_DATA_W,
    parameter int unsigned PORT     = rcp_pkg::RCP_PORT,
    parameter int unsigned TRIG_BIT = rcp_pkg::RCP_TRIG_BIT,
    parameter int unsigned KIND_BIT = rcp_pkg::RCP_KIND_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              sys_rst_req
);

    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT);

    logic wr_store, wr_trig, rd_sel;

    rcp_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT(PORT), .TRIG_BIT(TRIG_BIT)
    ) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .wr_store(wr_store), .wr_trig(wr_trig), .rd_sel(rd_sel)
    );

    rcp_store #(
        .DATA_W(DATA_W), .KIND_BIT(KIND_BIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_store(wr_store), .wr_trig(wr_trig),
        .rd_sel(rd_sel), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    rcp_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .wr_trig(wr_trig), .sys_rst_req(sys_rst_req)
    );

    // R4: a trigger write at the port raises the request one cycle later
    a_r4_req_next: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_A && io_wdata[TRIG_BIT]) |=> sys_rst_req);

    // R6 and R7: anything other than a trigger write keeps the request low next cycle
    a_r6_miss_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == PORT_A && io_wdata[TRIG_BIT]) |=> !sys_rst_req);

endmodule

// File: tb/sim_rst_ctl_port.sv
module sim_rst_ctl_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sys_rst_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_ctl_port u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0; io_addr = '0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; io_addr = '0;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        chk(sys_rst_req == 1'b0, "R1 req low in reset", {7'd0, sys_rst_req}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        do_read(16'h0CF9, r);
        chk(r == 8'h00, "R1 held byte after reset", r, 8'h00);
        chk(sys_rst_req == 1'b0, "R1 req low after reset", {7'd0, sys_rst_req}, 8'h00);
    endtask

    task automatic t_store;
        logic [7:0] r;
        do_write(16'h0CF9, 8'h02);
        do_read(16'h0CF9, r);
        chk(r == 8'h02, "R3 store kind bit", r, 8'h02);
        do_write(16'h0CF9, 8'hFB);
        do_read(16'h0CF9, r);
        chk(r == 8'h02, "R3 mask other bits", r, 8'h02);
        do_write(16'h0CF9, 8'h01);
        do_read(16'h0CF9, r);
        chk(r == 8'h00, "R3 clear kind bit", r, 8'h00);
        chk(sys_rst_req == 1'b0, "R3 store gives no req", {7'd0, sys_rst_req}, 8'h00);
    endtask

    task automatic t_trigger;
        logic [7:0] r;
        do_write(16'h0CF9, 8'h02);
        do_write(16'h0CF9, 8'h04);
        chk(sys_rst_req == 1'b1, "R4 req after trigger", {7'd0, sys_rst_req}, 8'h01);
        @(negedge clk);
        chk(sys_rst_req == 1'b0, "R5 pulse one cycle", {7'd0, sys_rst_req}, 8'h00);
        do_read(16'h0CF9, r);
        chk(r == 8'h02, "R4 trigger keeps held byte", r, 8'h02);
        do_write(16'h0CF9, 8'h04 | 8'h00);
        @(negedge clk);
        do_read(16'h0CF9, r);
        chk(r == 8'h02, "R4 trigger with bit1 clear keeps byte", r, 8'h02);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        io_addr = 16'h0CF9; io_wdata = 8'h06; io_wr = 1'b1;
        @(negedge clk);
        chk(sys_rst_req == 1'b1, "R5 first of two", {7'd0, sys_rst_req}, 8'h01);
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0; io_addr = '0;
        chk(sys_rst_req == 1'b1, "R5 second of two", {7'd0, sys_rst_req}, 8'h01);
        @(negedge clk);
        chk(sys_rst_req == 1'b0, "R5 ends after two", {7'd0, sys_rst_req}, 8'h00);
    endtask

    task automatic t_miss;
        logic [7:0] r;
        do_write(16'h0CF9, 8'h00);
        do_write(16'h0CF8, 8'h06);
        chk(sys_rst_req == 1'b0, "R6 no req at 0CF8", {7'd0, sys_rst_req}, 8'h00);
        do_write(16'h0CFA, 8'hFF);
        chk(sys_rst_req == 1'b0, "R6 no req at 0CFA", {7'd0, sys_rst_req}, 8'h00);
        do_write(16'h8CF9, 8'h06);
        chk(sys_rst_req == 1'b0, "R6 no req at 8CF9", {7'd0, sys_rst_req}, 8'h00);
        do_read(16'h0CF9, r);
        chk(r == 8'h00, "R6 held byte untouched", r, 8'h00);
    endtask

    task automatic t_read_gate;
        logic [7:0] r;
        do_write(16'h0CF9, 8'h02);
        do_read(16'h0CF8, r);
        chk(r == 8'h00, "R2 other address reads zero", r, 8'h00);
        @(negedge clk);
        io_addr = 16'h0CF9; io_rd = 1'b0;
        #1 chk(io_rdata == 8'h00, "R2 no strobe reads zero", io_rdata, 8'h00);
        io_rd = 1'b1; io_wdata = 8'h04;
        #1 chk(io_rdata == 8'h02, "R2 port read", io_rdata, 8'h02);
        @(negedge clk);
        chk(sys_rst_req == 1'b0, "R7 read gives no req", {7'd0, sys_rst_req}, 8'h00);
        #1 chk(io_rdata == 8'h02, "R7 read keeps byte", io_rdata, 8'h02);
        io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_store();
        t_trigger();
        t_back_to_back();
        t_miss();
        t_read_gate();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule